// File: doc/BRIEF.md
# Predicated Doubleword Prefetch Address Sequencer

The block takes one decoded vector contiguous-prefetch operation on 64-bit elements and turns it into a stream of prefetch requests, one for each element that the governing predicate enables. The address of element `e` is the base plus eight times (index + e). The block walks the elements in ascending order. The scalar index only advances inside the block; no register is ever written back. The base is either a general register value or the stack pointer value, depending on the base selector.

The operation comes in on a valid/ready handshake that is open only while the block is idle. Requests leave on a second valid/ready handshake, at most one per cycle. Every operation ends with a one-cycle `done` pulse. Two kinds of operation end at once, with no requests: an operation with an illegal index selector, and one with an unsupported vector length. For these, the matching error flag is raised alongside `done`. Each request carries a read/write hint, a two-bit cache level and a streaming flag, all split out of a 4-bit hint code.

Top module: `vpf_addr_seq`

## Requirements
- R1: Request addresses equal base + 8*(index + e) for element number e, and requests leave in ascending element order.
- R2: Element e is active when bit 8*e of the predicate row chosen by `op_pred_sel` is set. The other seven bits of each byte group are ignored. Bits for element numbers at or above `op_vl`/64 are ignored. Inactive elements produce no request.
- R3: The base is `op_sp_val` when `op_base_sel` equals 31, and `op_base_val` otherwise.
- R4: An `op_idx_sel` of 31 produces no requests. The cycle after acceptance, `done` and `undef` are both 1 and `vl_err` is 0; `undef` takes priority over a bad vector length.
- R5: The hint code splits into three request fields. Bit 3 drives `req_write` (1 means write). Bits 2:1 drive `req_level` as an unsigned number. Bit 0 drives `req_stream`.
- R6: A vector length that is zero, not a multiple of 128, or above 2048 produces no requests. In that case `done` and `vl_err` are both 1 in the cycle after acceptance.
- R7: While `req_valid` is 1 and `req_ready` is 0, the request fields hold steady. Exactly one request is consumed in each cycle where both are 1.
- R8: `done` is a single-cycle pulse. It comes in the cycle after the last request is taken, or in the cycle after acceptance when the operation has no active element.
- R9: `op_ready` is 1 only when the block is idle. Operation inputs are captured at acceptance, so `op_valid` and changes on the operation inputs while busy have no effect.
- R10: Address arithmetic wraps modulo 2^64.
- R11: After reset, `op_ready` is 1 and both `req_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Block idle, operation accepted when op_valid |
| op_base_sel | input | 5 | Base register number, 31 selects stack pointer |
| op_base_val | input | 64 | General register value for the base |
| op_sp_val | input | 64 | Stack pointer value |
| op_idx_sel | input | 5 | Index register number, 31 is undefined |
| op_idx_val | input | 64 | Index register value |
| op_pred_sel | input | 3 | Governing predicate row number |
| op_pred_file | input | 2048 | Eight predicate rows of 256 bits, row k at bits 256*k upward |
| op_vl | input | 13 | Vector length in bits |
| op_hint | input | 4 | Hint code: write, level, stream |
| req_valid | output | 1 | Prefetch request present |
| req_ready | input | 1 | Request taken |
| req_addr | output | 64 | Prefetch byte address |
| req_write | output | 1 | 1 for a write hint, 0 for a read hint |
| req_level | output | 2 | Cache level |
| req_stream | output | 1 | Streaming hint |
| done | output | 1 | Operation finished (one cycle) |
| undef | output | 1 | Undefined encoding, valid with done |
| vl_err | output | 1 | Unsupported vector length, valid with done |

## Verification
The hardest situation to reach from the ports combines three things in one operation. Requests are stalled partway through a sparse predicate, while a fresh `op_valid` carrying different base values is held against a busy block. The stimulus reaches it by randomizing `req_ready` on every cycle of every sequence. During the busy cycles of selected operations, it also raises `op_valid` with a scrambled base value. The expected request list is computed at the moment of acceptance, so any late capture or stray acceptance shows up as an address mismatch or a missing `done`.

// File: rtl/vpf_pkg.sv
package vpf_pkg;

  localparam int ADDR_W = 64;
  localparam int SCALE  = 3;

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_FIN} seq_state_e;

  typedef struct packed {
    logic       wr;
    logic [1:0] lvl;
    logic       strm;
  } pf_hint_t;

  // split the 4-bit hint code into request fields
  function automatic pf_hint_t split_hint(input logic [3:0] code);
    pf_hint_t h;
    h.wr   = code[3];
    h.lvl  = code[2:1];
    h.strm = code[0];
    return h;
  endfunction

  // byte address of element e, wrapping modulo 2^64
  function automatic logic [ADDR_W-1:0] elem_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [ADDR_W-1:0] idx,
                                                   input logic [ADDR_W-1:0] e);
    return base + ((idx + e) << SCALE);
  endfunction

endpackage

// File: rtl/vpf_decode.sv
module vpf_decode
  import vpf_pkg::*;
#(
  parameter int MAX_VL  = 2048,
  parameter int VL_GRAN = 128,
  parameter int ESIZE   = 64,
  parameter int VLW     = 13,
  parameter int CW      = 6
) (
  input  logic [4:0]     base_sel,
  input  logic [4:0]     idx_sel,
  input  logic [VLW-1:0] vl,
  input  logic [3:0]     code,
  output logic           use_sp,
  output logic           is_undef,
  output logic           is_vlbad,
  output logic [CW-1:0]  n_elem,
  output pf_hint_t       hint
);

  localparam logic [4:0]     SEL_SPECIAL = 5'd31;
  localparam logic [VLW-1:0] VL_MAX_V    = VLW'(MAX_VL);
  localparam logic [VLW-1:0] VL_GRAN_V   = VLW'(VL_GRAN);
  localparam logic [VLW-1:0] ESIZE_V     = VLW'(ESIZE);

  assign use_sp   = (base_sel == SEL_SPECIAL);
  assign is_undef = (idx_sel == SEL_SPECIAL);
  assign is_vlbad = (vl == '0) || ((vl % VL_GRAN_V) != '0) || (vl > VL_MAX_V);
  assign n_elem   = CW'(vl / ESIZE_V);
  assign hint     = split_hint(code);

endmodule

// File: rtl/vpf_mask_gather.sv
module vpf_mask_gather #(
  parameter int NPRED    = 8,
  parameter int MAX_PL   = 256,
  parameter int MAX_ELEM = 32,
  parameter int ESIZE    = 64,
  parameter int PSW      = 3,
  parameter int CW       = 6
) (
  input  logic [NPRED*MAX_PL-1:0] pred_file,
  input  logic [PSW-1:0]          sel,
  input  logic [CW-1:0]           n_elem,
  output logic [MAX_ELEM-1:0]     act
);

  localparam int STEP = ESIZE / 8;
  localparam int IW   = $clog2(NPRED * MAX_PL);

  logic [IW-1:0] row_base;
  assign row_base = IW'(sel) * IW'(MAX_PL);

  for (genvar e = 0; e < MAX_ELEM; e++) begin : g_elem
    logic [IW-1:0] pos;
    logic          in_range;
    assign pos      = row_base + IW'(e * STEP);
    assign in_range = (CW'(e) < n_elem);
    assign act[e]   = pred_file[pos] & in_range;
  end

endmodule

// File: rtl/vpf_pick.sv
module vpf_pick #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign any = |vec;

  // R2: the chosen element is one that is still pending
  a_r2_pick_hit: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> vec[idx]);

endmodule

// File: rtl/vpf_addr_seq.sv
module vpf_addr_seq
  import vpf_pkg::*;
#(
  parameter int MAX_VL  = 2048,
  parameter int VL_GRAN = 128,
  parameter int ESIZE   = 64,
  parameter int NPRED   = 8,
  localparam int MAX_ELEM = MAX_VL / ESIZE,
  localparam int MAX_PL   = MAX_VL / 8,
  localparam int PSW      = $clog2(NPRED),
  localparam int VLW      = $clog2(MAX_VL) + 2,
  localparam int CW       = $clog2(MAX_ELEM + 1),
  localparam int EIW      = $clog2(MAX_ELEM)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  output logic                    op_ready,
  input  logic [4:0]              op_base_sel,
  input  logic [63:0]             op_base_val,
  input  logic [63:0]             op_sp_val,
  input  logic [4:0]              op_idx_sel,
  input  logic [63:0]             op_idx_val,
  input  logic [PSW-1:0]          op_pred_sel,
  input  logic [NPRED*MAX_PL-1:0] op_pred_file,
  input  logic [VLW-1:0]          op_vl,
  input  logic [3:0]              op_hint,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [63:0]             req_addr,
  output logic                    req_write,
  output logic [1:0]              req_level,
  output logic                    req_stream,
  output logic                    done,
  output logic                    undef,
  output logic                    vl_err
);

  seq_state_e            state;
  logic [MAX_ELEM-1:0]   pend;
  logic [63:0]           base_q, idx_q;
  pf_hint_t              hint_q;
  logic                  undef_q, vlbad_q;

  // decoded operation
  logic                  use_sp, is_undef, is_vlbad;
  logic [CW-1:0]         n_elem;
  pf_hint_t              hint_d;
  logic [MAX_ELEM-1:0]   act;
  logic                  any_act;

  // named internal events
  logic                  accept;
  logic                  req_fire;
  logic                  pend_any;
  logic [EIW-1:0]        cur_idx;
  logic [MAX_ELEM-1:0]   pend_next;
  logic                  last_elem;
  logic                  issue_ok;

  vpf_decode #(
    .MAX_VL (MAX_VL),
    .VL_GRAN(VL_GRAN),
    .ESIZE  (ESIZE),
    .VLW    (VLW),
    .CW     (CW)
  ) i_decode (
    .base_sel(op_base_sel),
    .idx_sel (op_idx_sel),
    .vl      (op_vl),
    .code    (op_hint),
    .use_sp  (use_sp),
    .is_undef(is_undef),
    .is_vlbad(is_vlbad),
    .n_elem  (n_elem),
    .hint    (hint_d)
  );

  vpf_mask_gather #(
    .NPRED   (NPRED),
    .MAX_PL  (MAX_PL),
    .MAX_ELEM(MAX_ELEM),
    .ESIZE   (ESIZE),
    .PSW     (PSW),
    .CW      (CW)
  ) i_gather (
    .pred_file(op_pred_file),
    .sel      (op_pred_sel),
    .n_elem   (n_elem),
    .act      (act)
  );

  vpf_pick #(
    .N (MAX_ELEM),
    .IW(EIW)
  ) i_pick (
    .clk  (clk),
    .rst_n(rst_n),
    .vec  (pend),
    .any  (pend_any),
    .idx  (cur_idx)
  );

  assign any_act   = |act;
  assign op_ready  = (state == S_IDLE);
  assign accept    = op_valid && op_ready;
  assign issue_ok  = !is_undef && !is_vlbad && any_act;
  assign req_valid = (state == S_BUSY) && pend_any;
  assign req_fire  = req_valid && req_ready;
  assign pend_next = pend & ~(MAX_ELEM'(1) << cur_idx);
  assign last_elem = (pend_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pend    <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      hint_q  <= '0;
      undef_q <= 1'b0;
      vlbad_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            undef_q <= is_undef;
            vlbad_q <= !is_undef && is_vlbad;
            if (issue_ok) begin
              pend   <= act;
              base_q <= use_sp ? op_sp_val : op_base_val;
              idx_q  <= op_idx_val;
              hint_q <= hint_d;
              state  <= S_BUSY;
            end else begin
              state  <= S_FIN;
            end
          end
        end
        S_BUSY: begin
          if (req_fire) begin
            pend <= pend_next;
            if (last_elem) state <= S_FIN;
          end
        end
        S_FIN: begin
          undef_q <= 1'b0;
          vlbad_q <= 1'b0;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_addr   = elem_addr(base_q, idx_q, 64'(cur_idx));
  assign req_write  = hint_q.wr;
  assign req_level  = hint_q.lvl;
  assign req_stream = hint_q.strm;
  assign done       = (state == S_FIN);
  assign undef      = undef_q;
  assign vl_err     = vlbad_q;

  // R1: a taken request is followed by a higher element number or by nothing
  a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (!req_valid || (cur_idx > $past(cur_idx))));

  // R7: a stalled request holds all fields
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_write) && $stable(req_level) && $stable(req_stream)));

  // R8: done lasts one cycle and the block is then idle
  a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && op_ready));

  // R8: the end of a request stream is marked by done
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_valid) |-> done);

  // R9: no requests or completion while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (!req_valid && !done));

  // R4: undef only with done and never together with vl_err
  a_r4_undef_excl: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (done && !vl_err && !req_valid));

  // R6: vl_err only with done
  a_r6_vlerr_done: assert property (@(posedge clk) disable iff (!rst_n)
    vl_err |-> (done && !req_valid));

endmodule

// File: tb/test_vpf_addr_seq.sv
module test_vpf_addr_seq;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [4:0]    op_base_sel = '0;
  logic [63:0]   op_base_val = '0;
  logic [63:0]   op_sp_val = '0;
  logic [4:0]    op_idx_sel = '0;
  logic [63:0]   op_idx_val = '0;
  logic [2:0]    op_pred_sel = '0;
  logic [2047:0] op_pred_file = '0;
  logic [12:0]   op_vl = '0;
  logic [3:0]    op_hint = '0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [63:0]   req_addr;
  logic          req_write;
  logic [1:0]    req_level;
  logic          req_stream;
  logic          done, undef, vl_err;

  int n_chk = 0;
  int n_bad = 0;
  longint unsigned exp_q[$];

  always #5 clk = ~clk;

  vpf_addr_seq i_vpf_addr_seq (
    .clk, .rst_n, .op_valid, .op_ready, .op_base_sel, .op_base_val, .op_sp_val,
    .op_idx_sel, .op_idx_val, .op_pred_sel, .op_pred_file, .op_vl, .op_hint,
    .req_valid, .req_ready, .req_addr, .req_write, .req_level, .req_stream,
    .done, .undef, .vl_err
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // mark element e of predicate row r active (bit 8*e of the row)
  task automatic set_elems(input int r, input longint unsigned emask);
    for (int e = 0; e < 32; e++) op_pred_file[r*256 + e*8] = emask[e];
  endtask

  task automatic run_op(input logic [4:0] bsel, input logic [63:0] bval, input logic [63:0] spv,
                        input logic [4:0] isel, input logic [63:0] ival, input logic [2:0] psel,
                        input int vl, input logic [3:0] code, input bit noise, input string tag);
    bit exp_undef, exp_vlerr, rdy;
    longint unsigned b;
    int guard;
    exp_undef = (isel == 5'd31);
    exp_vlerr = !exp_undef && (vl == 0 || (vl % 128) != 0 || vl > 2048);
    b = (bsel == 5'd31) ? spv : bval;
    exp_q.delete();
    if (!exp_undef && !exp_vlerr)
      for (int e = 0; e < vl / 64; e++)
        if (op_pred_file[psel*256 + e*8]) exp_q.push_back(b + ival * 8 + longint'(e) * 8);

    @(negedge clk);
    chk(op_ready == 1'b1, {tag, " R9 ready idle"}, 64'(op_ready), 64'd1);
    op_base_sel = bsel; op_base_val = bval; op_sp_val = spv; op_idx_sel = isel;
    op_idx_val = ival; op_pred_sel = psel; op_vl = 13'(vl); op_hint = code;
    op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(op_ready == 1'b0, {tag, " R9 busy after accept"}, 64'(op_ready), 64'd0);
    guard = 0;
    while (exp_q.size() > 0 && guard < 2000) begin
      guard++;
      chk(req_valid == 1'b1, {tag, " R2 valid"}, 64'(req_valid), 64'd1);
      chk(req_addr == exp_q[0], {tag, " R1 R3 R10 addr"}, req_addr, exp_q[0]);
      chk({req_write, req_level, req_stream} == code, {tag, " R5 hint"},
          64'({req_write, req_level, req_stream}), 64'(code));
      chk(done == 1'b0, {tag, " R8 no early done"}, 64'(done), 64'd0);
      rdy = ($urandom % 3) != 0;
      req_ready = rdy;
      if (noise) begin
        op_valid = 1'b1;
        op_base_val = {$urandom, $urandom};
        op_sp_val = ~op_base_val;
      end
      @(posedge clk);
      if (rdy) void'(exp_q.pop_front());
      @(negedge clk);
      req_ready = 1'b0;
      op_valid = 1'b0;
    end
    chk(req_valid == 1'b0, {tag, " R2 R7 no extra request"}, 64'(req_valid), 64'd0);
    chk(done == 1'b1, {tag, " R8 done"}, 64'(done), 64'd1);
    chk(undef == exp_undef, {tag, " R4 undef"}, 64'(undef), 64'(exp_undef));
    chk(vl_err == exp_vlerr, {tag, " R6 vl_err"}, 64'(vl_err), 64'(exp_vlerr));
    @(negedge clk);
    chk(done == 1'b0 && op_ready == 1'b1, {tag, " R8 single pulse"}, 64'({done, op_ready}), 64'b01);
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(op_ready == 1'b1 && req_valid == 1'b0 && done == 1'b0, "R11 reset",
        64'({op_ready, req_valid, done}), 64'b100);
    rst_n = 1'b1;

    set_elems(0, 64'h3);
    run_op(5'd2, 64'h1000, 64'h9000, 5'd3, 64'd4, 3'd0, 128, 4'b0000, 1'b0, "R1 vl128 read");

    set_elems(5, 64'hFFFF_FFFF);
    run_op(5'd7, 64'h4_0000, 64'h0, 5'd1, 64'd10, 3'd5, 2048, 4'b1111, 1'b0, "R5 vl2048 write stream");

    set_elems(1, 64'hA5);
    run_op(5'd31, 64'hDEAD, 64'h7_0000, 5'd4, 64'd2, 3'd1, 512, 4'b0010, 1'b1, "R3 R9 sp base busy noise");

    // only non-group bits set: R2 group bits ignored
    op_pred_file[2*256 +: 256] = '0;
    for (int e = 0; e < 32; e++) op_pred_file[2*256 + e*8 + 1 + (e % 7)] = 1'b1;
    run_op(5'd0, 64'h100, 64'h0, 5'd0, 64'd0, 3'd2, 1024, 4'b0100, 1'b0, "R2 group bits ignored");

    // bit beyond element count ignored
    op_pred_file[3*256 +: 256] = '0;
    op_pred_file[3*256 + 4*8] = 1'b1;
    run_op(5'd0, 64'h100, 64'h0, 5'd0, 64'd0, 3'd3, 256, 4'b0000, 1'b0, "R2 beyond vl ignored");

    run_op(5'd0, 64'h100, 64'h0, 5'd31, 64'd0, 3'd5, 256, 4'b0000, 1'b0, "R4 undef index");
    run_op(5'd0, 64'h100, 64'h0, 5'd31, 64'd0, 3'd5, 192, 4'b0000, 1'b0, "R4 undef over bad vl");
    run_op(5'd0, 64'h100, 64'h0, 5'd6, 64'd0, 3'd5, 192, 4'b0000, 1'b0, "R6 vl 192");
    run_op(5'd0, 64'h100, 64'h0, 5'd6, 64'd0, 3'd5, 0, 4'b0000, 1'b0, "R6 vl 0");
    run_op(5'd0, 64'h100, 64'h0, 5'd6, 64'd0, 3'd5, 2176, 4'b0000, 1'b0, "R6 vl 2176");

    set_elems(4, 64'h8000_0013);
    run_op(5'd9, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 5'd8, 64'hFFFF_FFFF_FFFF_FFFF, 3'd4, 2048,
           4'b1010, 1'b1, "R10 wrap");

    set_elems(6, 64'h6);
    run_op(5'd12, 64'h2000, 64'h0, 5'd13, 64'd100, 3'd6, 384, 4'b0101, 1'b0, "R7 R1 sparse vl384");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule